// File: doc/BRIEF.md
# Staggered Output Gate Sequencer

This block turns a latched vector of per-channel on/off bits into a vector of driver gate signals whose switching instants are spread out in time. Before any delay is applied, the request for every channel is forced off while the active-low global enable is high or the thermal trip flag is set. Otherwise each channel requests its own latch bit. Channel n then follows its request only after n delay steps, where one step is `STEP_CYC` system clock cycles. The same delay applies to switching on and to switching off. Because the driver edges do not coincide, the inrush current and the ground bounce stay low.

Each channel has its own timer. A timer restarts whenever that channel's request changes. The gate therefore always ends at the most recent request, and the delay is counted from the most recent change. A request pulse shorter than a channel's delay never reaches that channel's gate. A settled flag tells a downstream sampler, such as an open-load detector, when every gate matches the captured request.

Top module: `stagger_gate_seq`

## Requirements
- R1: While reset is asserted, and until the first request change after reset, every gate bit is 0 and `allSettled` is 1.
- R2: With `oeN` low and `thermalTrip` low, the request of channel n is `latchBits[n]` (1 = on, 0 = off).
- R3: While `oeN` is 1, every channel's request is off, whatever `latchBits` holds.
- R4: While `thermalTrip` is 1, every channel's request is off, whatever `oeN` and `latchBits` hold.
- R5: Channel 0 has no extra delay. A request sampled at clock edge k appears on `gate[0]` after edge k+1.
- R6: Channel n lags channel 0 by n*`STEP_CYC` cycles, for on-to-off and off-to-on transitions alike. A request that changes at edge k and then holds appears on `gate[n]` after edge k+1+n*`STEP_CYC`.
- R7: When a channel's request changes again before its delay has run out, the timer restarts from the newest change and the gate ends at the newest value. A gate bit only ever takes a value its request held steadily for the full delay.
- R8: `allSettled` is 1 exactly when every gate bit equals the request captured at the most recent clock edge. While it is 1 the gates do not change on the next edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| latchBits | input | 16 | Latched per-channel on/off vector, 1 = on |
| oeN | input | 1 | Active-low global output enable |
| thermalTrip | input | 1 | Thermal shutdown flag, 1 forces all channels off |
| gate | output | 16 | Staggered driver gate signals, bit n drives channel n |
| allSettled | output | 1 | High when every gate matches the captured request |

## Verification
The delicate overlap is a channel's timer expiring in the very cycle a new request change arrives on that channel. In that cycle the gate must commit the value that was held for the full delay, and the timer must restart for the new value. The bench provokes this by toggling the latch vector with a period equal to one delay step, so that the expiries of channels 1, 2 and so on line up with fresh changes. It also flips the thermal trip and the global enable in the same cycle, so that the request stays off throughout. A behavioural model keeps a record of the last change edge for each channel. The bench compares the gate vector and the settled flag against this model on every clock.

// File: rtl/stagger_pkg.sv
package stagger_pkg;
  // number of driver channels served by one sequencer
  localparam int unsigned LANES = 16;

  // control-to-datapath strobes
  typedef struct packed {
    logic [LANES-1:0] commit;   // per-channel: load gate from captured request
  } seq_strobe_t;
endpackage

// File: rtl/stagger_gate_dp.sv
module stagger_gate_dp
  import stagger_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic [LANES-1:0] latchBits,
  input  logic             oeN,
  input  logic             thermalTrip,
  input  seq_strobe_t      strobes,
  output logic [LANES-1:0] chgVec,
  output logic [LANES-1:0] reqQ,
  output logic [LANES-1:0] gate
);
  logic             forceOff;
  logic [LANES-1:0] reqNow;

  assign forceOff = oeN | thermalTrip;
  assign reqNow   = forceOff ? '0 : latchBits;
  assign chgVec   = reqNow ^ reqQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      reqQ <= '0;
      gate <= '0;
    end else begin
      reqQ <= reqNow;
      gate <= (strobes.commit & reqQ) | (~strobes.commit & gate);
    end
  end
endmodule

// File: rtl/stagger_gate_ctl.sv
module stagger_gate_ctl
  import stagger_pkg::*;
#(
  parameter int unsigned STEP_CYC = 5
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [LANES-1:0] chgVec,
  output seq_strobe_t      strobes
);
  localparam int unsigned MAX_DLY = (LANES - 1) * STEP_CYC;
  localparam int unsigned AGE_W   = (MAX_DLY < 1) ? 1 : $clog2(MAX_DLY + 1);

  logic [LANES-1:0] commitVec;

  for (genvar ch = 0; ch < LANES; ch++) begin : g_lane
    localparam logic [AGE_W-1:0] LANE_DLY = AGE_W'(ch * STEP_CYC);
    logic [AGE_W-1:0] age;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)            age <= LANE_DLY;
      else if (chgVec[ch])  age <= '0;
      else if (age != LANE_DLY) age <= age + 1'b1;
    end

    assign commitVec[ch] = (age == LANE_DLY);
  end

  assign strobes.commit = commitVec;
endmodule

// File: rtl/stagger_gate_seq.sv
module stagger_gate_seq
  import stagger_pkg::*;
#(
  parameter int unsigned STEP_CYC = 5
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [LANES-1:0] latchBits,
  input  logic             oeN,
  input  logic             thermalTrip,
  output logic [LANES-1:0] gate,
  output logic             allSettled
);
  seq_strobe_t      strobes;
  logic [LANES-1:0] chgVec;
  logic [LANES-1:0] reqQ;

  stagger_gate_ctl #(.STEP_CYC(STEP_CYC)) u_ctl (
    .clk    (clk),
    .rstN   (rstN),
    .chgVec (chgVec),
    .strobes(strobes)
  );

  stagger_gate_dp u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .latchBits  (latchBits),
    .oeN        (oeN),
    .thermalTrip(thermalTrip),
    .strobes    (strobes),
    .chgVec     (chgVec),
    .reqQ       (reqQ),
    .gate       (gate)
  );

  assign allSettled = (gate == reqQ);
endmodule

// File: rtl/stagger_gate_chk.sv
module stagger_gate_chk
  import stagger_pkg::*;
(
  input logic             clk,
  input logic             rstN,
  input logic [LANES-1:0] latchBits,
  input logic             oeN,
  input logic             thermalTrip,
  input logic [LANES-1:0] gate,
  input logic             allSettled,
  input logic [LANES-1:0] reqQ
);
  logic [1:0]       warm;
  logic [LANES-1:0] wantNow;

  assign wantNow = (oeN || thermalTrip) ? '0 : latchBits;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          warm <= '0;
    else if (warm != 2) warm <= warm + 1'b1;
  end

  // R1
  rst_clear_chk: assert property (@(posedge clk)
    $rose(rstN) |-> (gate == '0 && allSettled));

  // R5
  lane0_track_chk: assert property (@(posedge clk) disable iff (!rstN)
    (warm == 2) |-> (gate[0] == $past(wantNow[0], 2)));

  // R3 R4
  forced_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    (warm == 2 && $past(oeN || thermalTrip, 2)) |-> ((gate & ~$past(gate)) == '0));

  // R7
  gate_source_chk: assert property (@(posedge clk) disable iff (!rstN)
    (warm != 0) |-> (((gate ^ $past(gate)) & (gate ^ $past(reqQ))) == '0));

  // R8
  settled_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    allSettled |=> $stable(gate));
endmodule

bind stagger_gate_seq stagger_gate_chk u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .latchBits  (latchBits),
  .oeN        (oeN),
  .thermalTrip(thermalTrip),
  .gate       (gate),
  .allSettled (allSettled),
  .reqQ       (reqQ)
);

// File: tb/sim_stagger_gate_seq.sv
`timescale 1ns/1ps
module sim_stagger_gate_seq;
  localparam int STEP = 5;
  localparam int NCH  = 16;

  logic            clk = 1'b0;
  logic            rstN = 1'b0;
  logic [NCH-1:0]  latchBits = '0;
  logic            oeN = 1'b1;
  logic            thermalTrip = 1'b0;
  logic [NCH-1:0]  gate;
  logic            allSettled;

  int    total = 0;
  int    bad = 0;
  bit    done = 0;
  string curReq = "R1";

  // model state
  int             edgeNo = 0;
  int             lastChg [NCH];
  logic [NCH-1:0] mReq = '0;
  logic [NCH-1:0] mGate = '0;

  stagger_gate_seq #(.STEP_CYC(STEP)) u0 (
    .clk(clk), .rstN(rstN), .latchBits(latchBits), .oeN(oeN),
    .thermalTrip(thermalTrip), .gate(gate), .allSettled(allSettled)
  );

  always #2 clk = ~clk;

  // behavioural reference: per channel, remember when its request last changed
  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      edgeNo = 0;
      mReq   = '0;
      mGate  = '0;
      for (int c = 0; c < NCH; c++) lastChg[c] = -1000000;
    end else begin
      logic [NCH-1:0] want;
      edgeNo++;
      for (int c = 0; c < NCH; c++)
        if (edgeNo - lastChg[c] >= c * STEP + 1) mGate[c] = mReq[c];
      want = (oeN || thermalTrip) ? '0 : latchBits;
      for (int c = 0; c < NCH; c++)
        if (want[c] != mReq[c]) lastChg[c] = edgeNo;
      mReq = want;
    end
  end

  task automatic compare();
    total++;
    if (gate !== mGate) begin
      bad++;
      $display("FAIL %s gate actual=%h expected=%h at t=%0t", curReq, gate, mGate, $time);
    end
    total++;
    if (allSettled !== (mGate == mReq)) begin
      bad++;
      $display("FAIL %s allSettled actual=%b expected=%b at t=%0t",
               curReq, allSettled, (mGate == mReq), $time);
    end
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      compare();
    end
  endtask

  initial begin
    for (int c = 0; c < NCH; c++) lastChg[c] = -1000000;
    // R1: reset state
    curReq = "R1";
    run(3);
    rstN = 1'b1;
    run(4);

    // R2: enabled, mixed pattern
    curReq = "R2";
    oeN = 1'b0;
    latchBits = 16'hA5C3;
    run(90);

    // R6: staggered turn-off then turn-on
    curReq = "R6";
    latchBits = 16'h0000;
    run(90);
    latchBits = 16'hFFFF;
    run(90);

    // R3: global enable high forces all off
    curReq = "R3";
    oeN = 1'b1;
    run(90);
    oeN = 1'b0;
    run(90);

    // R4: thermal trip forces all off, then recovery
    curReq = "R4";
    thermalTrip = 1'b1;
    run(90);
    thermalTrip = 1'b0;
    run(90);

    // R5: single toggles on channel 0 only
    curReq = "R5";
    latchBits = 16'hFFFE;
    run(3);
    latchBits = 16'hFFFF;
    run(3);
    latchBits = 16'hFFFE;
    run(90);

    // R7: short pulse, then changes on a step-period cadence
    curReq = "R7";
    latchBits = 16'h0000;
    run(12);
    latchBits = 16'hFFFF;
    run(90);
    for (int k = 0; k < 20; k++) begin
      latchBits = (k % 2 == 0) ? 16'h5A3C : 16'hC3A5;
      run(STEP);
    end
    run(90);
    for (int k = 0; k < 14; k++) begin
      latchBits = 16'(k * 16'h1F35 + 16'h0707);
      run(7);
    end
    run(90);

    // R8: thermal and enable flip in the same cycle
    curReq = "R8";
    latchBits = 16'hFFFF;
    run(90);
    thermalTrip = 1'b1;
    oeN = 1'b1;
    run(20);
    thermalTrip = 1'b0;
    run(10);
    oeN = 1'b0;
    run(90);

    // R1: reset mid-run clears everything
    curReq = "R1";
    @(negedge clk);
    rstN = 1'b0;
    run(3);
    rstN = 1'b1;
    run(90);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired during %s", curReq);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule